// File: doc/BRIEF.md
# SD Host Software Reset Controller

This block holds the 8-bit software reset register of an SD host controller and runs the reset sequences it starts. Software writes a 1 to one of three request bits to reset the data path, the command path or the whole controller. The block then drives scoped reset levels, a one-cycle buffer flush strobe and a card reset indication. A model of the controller state that those resets clear sits beside the sequencer: present-state flags, block-gap control bits, interrupt status bits, a generic host control register, a buffer fill counter, a synchronised card-detect bit and a capabilities register.

Each request bit reads 1 while its part is held in reset. It clears itself when the sequence it started ends. The data and command resets last a fixed number of cycles. The full reset lasts at least that long, then keeps its bit at 1 until the controller core reports that the capabilities are valid. The full reset never touches the card-detect bit or the capabilities register.

Top module: `sd_sw_reset_ctrl`

## Requirements
- R1: After power-on reset, `regRdData` reads 0x00 and every reset, flush and card reset output is low. Bits 7:3 of the register always read 0, and writes to them have no effect.
- R2: Writing 1 to bit 2 (data reset) while idle makes bit 2 read 1 and drives `rstDatOut` high from the clock edge that takes the write, for exactly HOLD_CYCLES (default 4) cycles. Bit 2 then reads 0 again.
- R3: The data reset clears `presState` bits 0 to 5, both `gapCtrl` bits and `irqStat` bits 0 to 3. It pulses `bufFlushOut` for one cycle in its first cycle and empties `bufCount`. It leaves `presState` bit 6, `irqStat` bit 4 and `hostCtrl` unchanged. Bit meanings: presState 0 buffer-read-enable, 1 buffer-write-enable, 2 read-transfer-active, 3 write-transfer-active, 4 data-line-active, 5 data-inhibit, 6 command-inhibit; gapCtrl 0 continue-request, 1 stop-at-gap-request; irqStat 0 buffer-read-ready, 1 buffer-write-ready, 2 gap-event, 3 transfer-done, 4 command-done.
- R4: Writing 1 to bit 1 (command reset) while idle makes bit 1 read 1 and drives `rstCmdOut` for exactly HOLD_CYCLES cycles. This clears only `presState` bit 6 and `irqStat` bit 4.
- R5: Writing 1 to bit 0 (full reset) clears every modelled flag, `hostCtrl` and `bufCount`. It drives `rstAllOut`, `rstDatOut` and `rstCmdOut` while bit 0 reads 1, and drives `cardResetOut` during the first HOLD_CYCLES cycles.
- R6: A full reset leaves `cardPresent` and `capsOut` unchanged. `capsOut` changes only on `capsLoad`.
- R7: Bit 0 reads 1 for at least HOLD_CYCLES+1 cycles. After the hold phase it returns to 0 on the first clock edge at which `capsValid` is high, and stays 1 for as long as `capsValid` is low.
- R8: Writing 0 to a request bit has no effect. Writing 1 to a request bit whose reset is already running neither restarts nor extends it.
- R9: When bit 0 is written together with bit 1 or bit 2, only the full reset starts. The register reads 0x01, and the data and command effects arrive through the full reset.
- R10: While a part is held in reset, its clear takes precedence over a set input for the flags it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read value (bit 2 data, bit 1 command, bit 0 full) |
| capsValid | input | 1 | Core reports capabilities readable |
| capsLoad | input | 1 | Loads the capabilities register |
| capsIn | input | CAPS_W | Capabilities load value |
| capsOut | output | CAPS_W | Capabilities register |
| cardDetectIn | input | 1 | Raw card-detect level |
| cardPresent | output | 1 | Synchronised card-detect bit |
| cardResetOut | output | 1 | Card must reset and be initialised again |
| rstDatOut | output | 1 | Data path held in reset |
| rstCmdOut | output | 1 | Command path held in reset |
| rstAllOut | output | 1 | Whole controller held in reset |
| bufFlushOut | output | 1 | One-cycle data buffer flush strobe |
| bufPush | input | 1 | Adds one word to the buffer fill model |
| bufCount | output | clog2(BUF_DEPTH+1) | Buffer fill count |
| presSet | input | 7 | Set inputs for the present-state flags |
| presState | output | 7 | Present-state flags |
| gapSet | input | 2 | Set inputs for the block-gap control bits |
| gapCtrl | output | 2 | Block-gap control bits |
| irqSet | input | 5 | Set inputs for the interrupt status bits |
| irqStat | output | 5 | Interrupt status bits |
| hostCtrlWe | input | 1 | Host control register write strobe |
| hostCtrlWd | input | HOST_W | Host control write data |
| hostCtrl | output | HOST_W | Generic host control register |

## Verification
The hardest case to reach is a full reset that stays parked after its hold phase because the core has not yet declared the capabilities valid. The bench holds `capsValid` low across a full reset for many cycles and then raises it on a chosen edge. A second hard case is a second write that lands in the middle of a running reset, or a set input that fights a clear. The bench places such a write and such set inputs on exact cycles inside the hold window. The main body sweeps all eight combinations of the three request bits from a fully set state. It computes the expected surviving flag masks and buffer count arithmetically.

// File: rtl/sd_rst_pkg.sv
package sd_rst_pkg;

  localparam int PRES_W = 7;
  localparam int GAP_W  = 2;
  localparam int IRQ_W  = 5;

  localparam int REQ_ALL_BIT = 0;
  localparam int REQ_CMD_BIT = 1;
  localparam int REQ_DAT_BIT = 2;
  localparam int REQ_W       = 3;
  localparam int REG_W       = 8;

  localparam logic [PRES_W-1:0] PRES_DAT_MASK = 7'h3F;
  localparam logic [PRES_W-1:0] PRES_CMD_MASK = 7'h40;
  localparam logic [GAP_W-1:0]  GAP_DAT_MASK  = 2'h3;
  localparam logic [IRQ_W-1:0]  IRQ_DAT_MASK  = 5'h0F;
  localparam logic [IRQ_W-1:0]  IRQ_CMD_MASK  = 5'h10;

  typedef struct packed {
    logic clrDat;
    logic clrCmd;
    logic clrAll;
    logic flush;
  } rstStrobe_t;

  typedef enum logic [1:0] {
    ALL_IDLE    = 2'd0,
    ALL_HOLD    = 2'd1,
    ALL_WAITCAP = 2'd2
  } allState_t;

endpackage

// File: rtl/sd_rst_chan.sv
module sd_rst_chan #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic block,
  output logic active,
  output logic first
);

  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == CW'(HOLD - 1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start && !block) begin
      active <= 1'b1;
      cnt    <= '0;
    end
  end

  assign first = active && (cnt == '0);

  AST_CHAN_HOLD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> ($past(cnt) == CW'(HOLD - 1))); // R2

  AST_CHAN_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (active && cnt != CW'(HOLD - 1)) |=> (active && cnt == $past(cnt) + 1'b1)); // R8

endmodule

// File: rtl/sd_rst_control.sv
module sd_rst_control
  import sd_rst_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REQ_W-1:0] reqWr,
  input  logic             capsValid,
  output rstStrobe_t       strobe,
  output logic [REQ_W-1:0] reqState,
  output logic             cardReset
);

  localparam int HCW = $clog2(HOLD_CYCLES + 1);

  allState_t      allState;
  logic [HCW-1:0] holdCnt;
  logic           allBusy;
  logic           allStart;
  logic [1:0]     chanActive;
  logic [1:0]     chanFirst;

  assign allBusy  = (allState != ALL_IDLE);
  assign allStart = regWrEn && reqWr[REQ_ALL_BIT] && !allBusy;

  // channel 0 serves the command bit, channel 1 the data bit
  for (genvar g = 0; g < 2; g++) begin : g_chan
    sd_rst_chan #(.HOLD(HOLD_CYCLES)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .start  (regWrEn && reqWr[REQ_CMD_BIT + g]),
      .block  (allBusy || allStart),
      .active (chanActive[g]),
      .first  (chanFirst[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allState <= ALL_IDLE;
      holdCnt  <= '0;
    end else begin
      case (allState)
        ALL_IDLE: begin
          if (allStart) begin
            allState <= ALL_HOLD;
            holdCnt  <= '0;
          end
        end
        ALL_HOLD: begin
          if (holdCnt == HCW'(HOLD_CYCLES - 1)) begin
            allState <= ALL_WAITCAP;
            holdCnt  <= '0;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        ALL_WAITCAP: begin
          if (capsValid) allState <= ALL_IDLE;
        end
        default: allState <= ALL_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clrDat = chanActive[1] || allBusy;
    strobe.clrCmd = chanActive[0] || allBusy;
    strobe.clrAll = allBusy;
    strobe.flush  = chanFirst[1] || (allState == ALL_HOLD && holdCnt == '0);
  end

  always_comb begin
    reqState              = '0;
    reqState[REQ_ALL_BIT] = allBusy;
    reqState[REQ_CMD_BIT] = chanActive[0];
    reqState[REQ_DAT_BIT] = chanActive[1];
  end

  assign cardReset = (allState == ALL_HOLD);

  AST_ALL_EXIT_ON_CAPS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(allBusy) |-> $past(capsValid)); // R7

  AST_CARD_RST_IN_ALL: assert property (@(posedge clk) disable iff (!rstN)
    cardReset |-> reqState[REQ_ALL_BIT]); // R5

  AST_ALL_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (allStart && !chanActive[0] && !chanActive[1]) |=>
      (reqState == 3'b001)); // R9

endmodule

// File: rtl/sd_rst_datapath.sv
module sd_rst_datapath
  import sd_rst_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int CAPS_W    = 16,
  parameter int HOST_W    = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  rstStrobe_t                     strobe,
  input  logic                           capsLoad,
  input  logic [CAPS_W-1:0]              capsIn,
  output logic [CAPS_W-1:0]              capsOut,
  input  logic                           cardDetectIn,
  output logic                           cardPresent,
  input  logic                           bufPush,
  output logic [$clog2(BUF_DEPTH+1)-1:0] bufCount,
  input  logic [PRES_W-1:0]              presSet,
  output logic [PRES_W-1:0]              presState,
  input  logic [GAP_W-1:0]               gapSet,
  output logic [GAP_W-1:0]               gapCtrl,
  input  logic [IRQ_W-1:0]               irqSet,
  output logic [IRQ_W-1:0]               irqStat,
  input  logic                           hostCtrlWe,
  input  logic [HOST_W-1:0]              hostCtrlWd,
  output logic [HOST_W-1:0]              hostCtrl
);

  localparam int BCW = $clog2(BUF_DEPTH + 1);

  logic [PRES_W-1:0] presClr;
  logic [GAP_W-1:0]  gapClr;
  logic [IRQ_W-1:0]  irqClr;
  logic              detSync;

  assign presClr = ({PRES_W{strobe.clrDat}} & PRES_DAT_MASK)
                 | ({PRES_W{strobe.clrCmd}} & PRES_CMD_MASK)
                 | {PRES_W{strobe.clrAll}};
  assign gapClr  = ({GAP_W{strobe.clrDat}} & GAP_DAT_MASK)
                 | {GAP_W{strobe.clrAll}};
  assign irqClr  = ({IRQ_W{strobe.clrDat}} & IRQ_DAT_MASK)
                 | ({IRQ_W{strobe.clrCmd}} & IRQ_CMD_MASK)
                 | {IRQ_W{strobe.clrAll}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presState <= '0;
      gapCtrl   <= '0;
      irqStat   <= '0;
    end else begin
      presState <= (presState | presSet) & ~presClr;
      gapCtrl   <= (gapCtrl | gapSet) & ~gapClr;
      irqStat   <= (irqStat | irqSet) & ~irqClr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hostCtrl <= '0;
    else if (strobe.clrAll)    hostCtrl <= '0;
    else if (hostCtrlWe)       hostCtrl <= hostCtrlWd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufCount <= '0;
    end else if (strobe.flush) begin
      bufCount <= '0;
    end else if (bufPush && !strobe.clrDat && bufCount != BCW'(BUF_DEPTH)) begin
      bufCount <= bufCount + 1'b1;
    end
  end

  // power-on reset only: software resets leave these alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detSync     <= 1'b0;
      cardPresent <= 1'b0;
      capsOut     <= '0;
    end else begin
      detSync     <= cardDetectIn;
      cardPresent <= detSync;
      if (capsLoad) capsOut <= capsIn;
    end
  end

  AST_DAT_SCOPE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrDat |=> ((presState & PRES_DAT_MASK) == '0 && gapCtrl == '0 &&
                       (irqStat & IRQ_DAT_MASK) == '0)); // R3

  AST_CMD_SCOPE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCmd |=> ((presState & PRES_CMD_MASK) == '0 &&
                       (irqStat & IRQ_CMD_MASK) == '0)); // R4

  AST_ALL_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (hostCtrl == '0)); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (bufCount == '0)); // R3

  AST_CAPS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrAll && !capsLoad) |=> $stable(capsOut)); // R6

endmodule

// File: rtl/sd_sw_reset_ctrl.sv
module sd_sw_reset_ctrl
  import sd_rst_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int BUF_DEPTH   = 16,
  parameter int CAPS_W      = 16,
  parameter int HOST_W      = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [REG_W-1:0]               regWrData,
  output logic [REG_W-1:0]               regRdData,
  input  logic                           capsValid,
  input  logic                           capsLoad,
  input  logic [CAPS_W-1:0]              capsIn,
  output logic [CAPS_W-1:0]              capsOut,
  input  logic                           cardDetectIn,
  output logic                           cardPresent,
  output logic                           cardResetOut,
  output logic                           rstDatOut,
  output logic                           rstCmdOut,
  output logic                           rstAllOut,
  output logic                           bufFlushOut,
  input  logic                           bufPush,
  output logic [$clog2(BUF_DEPTH+1)-1:0] bufCount,
  input  logic [PRES_W-1:0]              presSet,
  output logic [PRES_W-1:0]              presState,
  input  logic [GAP_W-1:0]               gapSet,
  output logic [GAP_W-1:0]               gapCtrl,
  input  logic [IRQ_W-1:0]               irqSet,
  output logic [IRQ_W-1:0]               irqStat,
  input  logic                           hostCtrlWe,
  input  logic [HOST_W-1:0]              hostCtrlWd,
  output logic [HOST_W-1:0]              hostCtrl
);

  rstStrobe_t       strobe;
  logic [REQ_W-1:0] reqState;
  logic             unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:REQ_W];

  sd_rst_control #(.HOLD_CYCLES(HOLD_CYCLES)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .reqWr     (regWrData[REQ_W-1:0]),
    .capsValid (capsValid),
    .strobe    (strobe),
    .reqState  (reqState),
    .cardReset (cardResetOut)
  );

  sd_rst_datapath #(
    .BUF_DEPTH (BUF_DEPTH),
    .CAPS_W    (CAPS_W),
    .HOST_W    (HOST_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .capsLoad     (capsLoad),
    .capsIn       (capsIn),
    .capsOut      (capsOut),
    .cardDetectIn (cardDetectIn),
    .cardPresent  (cardPresent),
    .bufPush      (bufPush),
    .bufCount     (bufCount),
    .presSet      (presSet),
    .presState    (presState),
    .gapSet       (gapSet),
    .gapCtrl      (gapCtrl),
    .irqSet       (irqSet),
    .irqStat      (irqStat),
    .hostCtrlWe   (hostCtrlWe),
    .hostCtrlWd   (hostCtrlWd),
    .hostCtrl     (hostCtrl)
  );

  assign regRdData   = {{(REG_W-REQ_W){1'b0}}, reqState};
  assign rstDatOut   = strobe.clrDat;
  assign rstCmdOut   = strobe.clrCmd;
  assign rstAllOut   = strobe.clrAll;
  assign bufFlushOut = strobe.flush;

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn) |-> (regRdData[REG_W-1:REQ_W] == '0)); // R1

endmodule

// File: tb/sd_sw_reset_ctrl_bench.sv
module sd_sw_reset_ctrl_bench;

  localparam int BUF_DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        capsValid = 1'b1;
  logic        capsLoad = 1'b0;
  logic [15:0] capsIn = '0;
  logic [15:0] capsOut;
  logic        cardDetectIn = 1'b1;
  logic        cardPresent;
  logic        cardResetOut;
  logic        rstDatOut;
  logic        rstCmdOut;
  logic        rstAllOut;
  logic        bufFlushOut;
  logic        bufPush = 1'b0;
  logic [4:0]  bufCount;
  logic [6:0]  presSet = '0;
  logic [6:0]  presState;
  logic [1:0]  gapSet = '0;
  logic [1:0]  gapCtrl;
  logic [4:0]  irqSet = '0;
  logic [4:0]  irqStat;
  logic        hostCtrlWe = 1'b0;
  logic [7:0]  hostCtrlWd = '0;
  logic [7:0]  hostCtrl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sd_sw_reset_ctrl u_sd_sw_reset_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .capsValid(capsValid), .capsLoad(capsLoad),
    .capsIn(capsIn), .capsOut(capsOut), .cardDetectIn(cardDetectIn),
    .cardPresent(cardPresent), .cardResetOut(cardResetOut),
    .rstDatOut(rstDatOut), .rstCmdOut(rstCmdOut), .rstAllOut(rstAllOut),
    .bufFlushOut(bufFlushOut), .bufPush(bufPush), .bufCount(bufCount),
    .presSet(presSet), .presState(presState), .gapSet(gapSet),
    .gapCtrl(gapCtrl), .irqSet(irqSet), .irqStat(irqStat),
    .hostCtrlWe(hostCtrlWe), .hostCtrlWd(hostCtrlWd), .hostCtrl(hostCtrl)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // drives a write at a negedge; returns at the negedge after the edge that took it
  task automatic regWrite(input logic [7:0] val);
    regWrEn   = 1'b1;
    regWrData = val;
    @(negedge clk);
    regWrEn   = 1'b0;
    regWrData = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int bufModel = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 read after reset", regRdData, 8'h00);
    check("R1 reset outputs idle",
          {rstDatOut, rstCmdOut, rstAllOut, bufFlushOut, cardResetOut}, 5'h0);
    capsIn = 16'hC0DE; capsLoad = 1'b1;
    @(negedge clk);
    capsLoad = 1'b0; capsIn = 16'h0;
    check("R6 caps loaded", capsOut, 16'hC0DE);

    // sweep every combination of the three request bits from a fully set state
    for (int v = 0; v < 8; v++) begin
      logic [2:0] w;
      logic dExp, cExp, aExp;
      logic [7:0] rdFirst;
      logic [6:0] presMask;
      logic [4:0] irqMask;
      w = 3'(v);
      dExp = w[2] | w[0];
      cExp = w[1] | w[0];
      aExp = w[0];
      rdFirst = w[0] ? 8'h01 : {5'b0, w[2], w[1], 1'b0};
      presMask = w[0] ? 7'h7F : ((w[2] ? 7'h3F : 7'h00) | (w[1] ? 7'h40 : 7'h00));
      irqMask  = w[0] ? 5'h1F : ((w[2] ? 5'h0F : 5'h00) | (w[1] ? 5'h10 : 5'h00));

      presSet = '1; gapSet = '1; irqSet = '1; hostCtrlWe = 1'b1; hostCtrlWd = 8'hA5; bufPush = 1'b1;
      repeat (3) @(negedge clk);
      presSet = '0; gapSet = '0; irqSet = '0; hostCtrlWe = 1'b0; bufPush = 1'b0;
      bufModel = (bufModel + 3 > BUF_DEPTH) ? BUF_DEPTH : bufModel + 3;

      regWrite({5'b10110, w});
      check($sformatf("R2 R4 R5 R9 read first cycle v=%0d", v), regRdData, rdFirst);
      check($sformatf("R2 R5 rstDat v=%0d", v), rstDatOut, dExp);
      check($sformatf("R4 R5 rstCmd v=%0d", v), rstCmdOut, cExp);
      check($sformatf("R5 rstAll v=%0d", v), rstAllOut, aExp);
      check($sformatf("R3 flush pulse v=%0d", v), bufFlushOut, dExp);
      check($sformatf("R5 card reset v=%0d", v), cardResetOut, aExp);
      @(negedge clk);
      check($sformatf("R3 flush single cycle v=%0d", v), bufFlushOut, 1'b0);
      repeat (2) @(negedge clk);
      check($sformatf("R2 R4 read last hold cycle v=%0d", v), regRdData, rdFirst);
      @(negedge clk);
      check($sformatf("R2 R4 R7 read after hold v=%0d", v), regRdData, {7'b0, aExp});
      check($sformatf("R5 card reset ends v=%0d", v), cardResetOut, 1'b0);
      check($sformatf("R5 rstDat during caps wait v=%0d", v), rstDatOut, aExp);
      @(negedge clk);
      check($sformatf("R7 read idle v=%0d", v), regRdData, 8'h00);
      check($sformatf("R2 R5 outputs idle v=%0d", v),
            {rstDatOut, rstCmdOut, rstAllOut}, 3'b000);

      if (dExp) bufModel = 0;
      check($sformatf("R3 R4 R5 R8 presState v=%0d", v), presState, 7'h7F & ~presMask);
      check($sformatf("R3 R5 R8 gapCtrl v=%0d", v), gapCtrl, dExp ? 2'b00 : 2'b11);
      check($sformatf("R3 R4 R5 R8 irqStat v=%0d", v), irqStat, 5'h1F & ~irqMask);
      check($sformatf("R3 R5 hostCtrl v=%0d", v), hostCtrl, aExp ? 8'h00 : 8'hA5);
      check($sformatf("R3 R5 bufCount v=%0d", v), bufCount, 5'(bufModel));
      check($sformatf("R6 cardPresent v=%0d", v), cardPresent, 1'b1);
      check($sformatf("R6 capsOut v=%0d", v), capsOut, 16'hC0DE);
    end

    // R7: full reset parked while capabilities are not valid
    capsValid = 1'b0;
    regWrite(8'h01);
    repeat (12) @(negedge clk);
    check("R7 bit0 held while caps invalid", regRdData, 8'h01);
    check("R7 rstAll held while caps invalid", rstAllOut, 1'b1);
    check("R5 card reset only in hold phase", cardResetOut, 1'b0);
    capsValid = 1'b1;
    @(negedge clk);
    check("R7 bit0 clears on caps valid", regRdData, 8'h00);
    check("R6 caps survive parked reset", capsOut, 16'hC0DE);

    // R8: second write to a running data reset neither restarts nor extends it
    regWrite(8'h04);
    @(negedge clk);
    regWrite(8'h04);
    @(negedge clk);
    check("R8 data reset still running", regRdData, 8'h04);
    @(negedge clk);
    check("R8 data reset not extended", regRdData, 8'h00);
    check("R8 rstDat not extended", rstDatOut, 1'b0);

    // R10: set inputs lose against a running clear
    regWrite(8'h04);
    presSet = 7'h41; irqSet = 5'h11;
    repeat (3) @(negedge clk);
    check("R10 presState data flag held clear", presState[0], 1'b0);
    check("R10 irqStat data flag held clear", irqStat[0], 1'b0);
    check("R10 command flags outside scope set", {presState[6], irqStat[4]}, 2'b11);
    presSet = '0; irqSet = '0;
    repeat (2) @(negedge clk);
    check("R10 data flags stay clear", {presState[0], irqStat[0]}, 2'b00);

    // R1: write touching only unused bits does nothing
    regWrite(8'hF8);
    check("R1 unused bits ignored", regRdData, 8'h00);
    check("R1 no reset from unused bits", {rstDatOut, rstCmdOut, rstAllOut}, 3'b000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule